// File: doc/BRIEF.md
# Dual-Channel Priority Bus Arbiter with Ownership Lock

This block decides which of several masters owns a shared synchronous on-chip bus. The bus is not multiplexed, and its read and write data paths are separate. Each channel has its own owner, so one master can hold the read path while another holds the write path. Every master gives each channel a request, a lock flag, a burst-length field, a burst-continue signal and a 32-bit address. The block returns a one-hot grant, a final-beat flag and the address of the current owner. The slave signals each completed beat with a single acknowledge per channel.

A configuration write port sets each master's priority, and both channels use these priorities. A higher value wins. Masters tied on priority take turns in round-robin order, starting after the last master granted on that channel. The next owner is chosen in the same cycle as the acknowledged final beat, and its grant appears on the following cycle, so the bus does not sit idle between owners. A master that still holds its lock at the end of its transfer keeps the channel. No other master is granted until that master drops the lock.

Top module: `bus_arbiter`

## Requirements
- R1: On each channel at most one grant bit is high in any cycle. The grant is a registered one-hot vector, with bit i set when master i owns the channel.
- R2: After synchronous reset no grant is set on either channel, the final-beat flag and the owner address are 0, no lock is held, every priority is 0, and the round-robin order starts at master 0.
- R3: A channel decides at an arbitration point: a cycle with no owner, or a cycle whose final beat is acknowledged. Only a master requesting in that cycle can win, and its grant appears in the next cycle.
- R4: Among the eligible requesters, the master with the numerically highest priority wins.
- R5: Among eligible requesters of equal highest priority, the winner is the first one at or above the master index after the last master granted on that channel, wrapping from master NM-1 back to master 0.
- R6: A nonzero burst-length value L gives a fixed burst of L beats. The final-beat flag is high during beat L. The grant holds until beat L is acknowledged, and beats that are not acknowledged do not count. An acknowledge while the channel has no owner has no effect.
- R7: A burst-length value of 0 gives a variable burst. The final beat is the acknowledged beat in which the owner's burst-continue signal is low, and the final-beat flag follows that signal while the burst is in progress.
- R8: In the cycle after the final beat is acknowledged, the grant shows the next winner, with no idle cycle between owners. If nothing is eligible, the grant shows 0.
- R9: If the owner's lock flag is high when it wins, and is still high at a later arbitration point, only that master is eligible on that channel. The channel stays ungranted until that master requests again or lowers its lock.
- R10: A priority write (index, value) never changes the owner of a transfer already in progress. The new value is used from the next arbitration point on.
- R11: The read and write channels arbitrate, count beats and lock independently. Activity on one channel does not change the grant on the other.
- R12: Each channel's bus address equals the address input of its current owner, and is 0 when the channel has no owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_idx | input | IW | Master index for the priority write |
| cfg_prio | input | PW | Priority value to write |
| rd_req | input | NM | Read channel requests, one bit per master |
| rd_lock | input | NM | Read channel lock flags |
| rd_burst | input | NM | Read burst-continue signals (variable bursts) |
| rd_len | input | NM x LW | Read burst lengths, 0 = variable |
| rd_addr | input | NM x AW | Read addresses, one per master |
| rd_ack | input | 1 | Read beat acknowledge from the slave |
| rd_gnt | output | NM | Read one-hot grant |
| rd_last | output | 1 | Read final-beat flag |
| rd_bus_addr | output | AW | Address of the read owner |
| wr_req | input | NM | Write channel requests |
| wr_lock | input | NM | Write channel lock flags |
| wr_burst | input | NM | Write burst-continue signals |
| wr_len | input | NM x LW | Write burst lengths, 0 = variable |
| wr_addr | input | NM x AW | Write addresses |
| wr_ack | input | 1 | Write beat acknowledge |
| wr_gnt | output | NM | Write one-hot grant |
| wr_last | output | 1 | Write final-beat flag |
| wr_bus_addr | output | AW | Address of the write owner |

## Verification
The hardest case to reach is the interaction of the round-robin pointer with programmed priorities. The pointer's state depends on the whole grant history, so a few directed cases cannot cover it. The stimulus sweeps every priority assignment and every request mask on both channels while a bench model tracks the pointer. A locked owner that stops requesting while others wait needs a set sequence: the lock is held through the final acknowledge with the request dropped, the grant is held at 0 for several cycles, and the holder then requests again before releasing the lock. A priority rewrite lands mid-burst, timed so that the old and new values pick different next winners.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int ARB_NM = 4;
    localparam int ARB_PW = 2;
    localparam int ARB_LW = 4;
    localparam int ARB_AW = 32;

    typedef enum logic {
        BM_FIXED = 1'b0,
        BM_VAR   = 1'b1
    } burst_mode_e;

    function automatic int wrap_idx(int base, int step, int n);
        return (base + step) % n;
    endfunction

    function automatic burst_mode_e mode_of_len(int len);
        return (len == 0) ? BM_VAR : BM_FIXED;
    endfunction

endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs #(
    parameter int NM = 4,
    parameter int PW = 2,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [IW-1:0]          idx,
    input  logic [PW-1:0]          val,
    output logic [NM-1:0][PW-1:0]  prio
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prio <= '0;
        end else if (we) begin
            for (int i = 0; i < NM; i++) begin
                if (int'(idx) == i) prio[i] <= val;
            end
        end
    end

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NM = 4,
    parameter int PW = 2,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0]          elig,
    input  logic [NM-1:0][PW-1:0]  prio,
    input  logic [IW-1:0]          ptr,
    output logic                   found,
    output logic [IW-1:0]          win
);

    logic [IW-1:0] cand;
    logic [PW-1:0] best;

    // Scan starting just after the pointer; only a strictly higher priority
    // displaces the current pick, so equal priorities resolve in scan order.
    always_comb begin
        found = 1'b0;
        win   = '0;
        best  = '0;
        cand  = '0;
        for (int k = 1; k <= NM; k++) begin
            cand = IW'(arb_pkg::wrap_idx(int'(ptr), k, NM));
            if (elig[cand] && (!found || prio[cand] > best)) begin
                found = 1'b1;
                win   = cand;
                best  = prio[cand];
            end
        end
    end

endmodule

// File: rtl/arb_channel.sv
module arb_channel #(
    parameter int NM = 4,
    parameter int PW = 2,
    parameter int LW = 4,
    parameter int AW = 32,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NM-1:0][PW-1:0]  prio,
    input  logic [NM-1:0]          req,
    input  logic [NM-1:0]          lock,
    input  logic [NM-1:0]          burst,
    input  logic [NM-1:0][LW-1:0]  len,
    input  logic [NM-1:0][AW-1:0]  addr,
    input  logic                   ack,
    output logic [NM-1:0]          gnt,
    output logic                   last,
    output logic [AW-1:0]          bus_addr
);

    typedef struct packed {
        logic                  vld;
        logic [IW-1:0]         idx;
        arb_pkg::burst_mode_e  mode;
        logic [LW-1:0]         len;
        logic [LW-1:0]         cnt;
    } owner_t;

    owner_t        own_q;
    logic          hold_vld_q;
    logic [IW-1:0] hold_idx_q;
    logic [IW-1:0] rr_ptr_q;

    logic          is_last;
    logic          arb_pt;
    logic          hold_eff;
    logic [NM-1:0] hold_mask;
    logic [NM-1:0] elig;
    logic          found;
    logic [IW-1:0] win;

    always_comb begin
        if (!own_q.vld)
            is_last = 1'b0;
        else if (own_q.mode == arb_pkg::BM_VAR)
            is_last = !burst[own_q.idx];
        else
            is_last = (own_q.cnt == own_q.len - LW'(1));
    end

    assign arb_pt   = !own_q.vld || (ack && is_last);
    assign hold_eff = hold_vld_q && lock[hold_idx_q];

    always_comb begin
        hold_mask = '1;
        if (hold_eff) begin
            hold_mask = '0;
            hold_mask[hold_idx_q] = 1'b1;
        end
    end

    assign elig = req & hold_mask;

    arb_pick #(.NM(NM), .PW(PW)) u_pick (
        .elig  (elig),
        .prio  (prio),
        .ptr   (rr_ptr_q),
        .found (found),
        .win   (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q      <= '0;
            hold_vld_q <= 1'b0;
            hold_idx_q <= '0;
            rr_ptr_q   <= IW'(NM - 1);
        end else if (arb_pt) begin
            if (found) begin
                own_q.vld  <= 1'b1;
                own_q.idx  <= win;
                own_q.mode <= arb_pkg::mode_of_len(int'(len[win]));
                own_q.len  <= len[win];
                own_q.cnt  <= '0;
                hold_vld_q <= lock[win];
                hold_idx_q <= win;
                rr_ptr_q   <= win;
            end else begin
                own_q      <= '0;
                hold_vld_q <= hold_eff;
            end
        end else if (ack) begin
            own_q.cnt <= own_q.cnt + LW'(1);
        end
    end

    always_comb begin
        gnt = '0;
        if (own_q.vld) gnt[own_q.idx] = 1'b1;
    end

    assign last     = is_last;
    assign bus_addr = own_q.vld ? addr[own_q.idx] : '0;

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int NM = arb_pkg::ARB_NM,
    parameter int PW = arb_pkg::ARB_PW,
    parameter int LW = arb_pkg::ARB_LW,
    parameter int AW = arb_pkg::ARB_AW,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [IW-1:0]          cfg_idx,
    input  logic [PW-1:0]          cfg_prio,
    input  logic [NM-1:0]          rd_req,
    input  logic [NM-1:0]          rd_lock,
    input  logic [NM-1:0]          rd_burst,
    input  logic [NM-1:0][LW-1:0]  rd_len,
    input  logic [NM-1:0][AW-1:0]  rd_addr,
    input  logic                   rd_ack,
    output logic [NM-1:0]          rd_gnt,
    output logic                   rd_last,
    output logic [AW-1:0]          rd_bus_addr,
    input  logic [NM-1:0]          wr_req,
    input  logic [NM-1:0]          wr_lock,
    input  logic [NM-1:0]          wr_burst,
    input  logic [NM-1:0][LW-1:0]  wr_len,
    input  logic [NM-1:0][AW-1:0]  wr_addr,
    input  logic                   wr_ack,
    output logic [NM-1:0]          wr_gnt,
    output logic                   wr_last,
    output logic [AW-1:0]          wr_bus_addr
);

    logic [NM-1:0][PW-1:0] prio;

    arb_prio_regs #(.NM(NM), .PW(PW)) u_prio (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .idx  (cfg_idx),
        .val  (cfg_prio),
        .prio (prio)
    );

    arb_channel #(.NM(NM), .PW(PW), .LW(LW), .AW(AW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .prio     (prio),
        .req      (rd_req),
        .lock     (rd_lock),
        .burst    (rd_burst),
        .len      (rd_len),
        .addr     (rd_addr),
        .ack      (rd_ack),
        .gnt      (rd_gnt),
        .last     (rd_last),
        .bus_addr (rd_bus_addr)
    );

    arb_channel #(.NM(NM), .PW(PW), .LW(LW), .AW(AW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .prio     (prio),
        .req      (wr_req),
        .lock     (wr_lock),
        .burst    (wr_burst),
        .len      (wr_len),
        .addr     (wr_addr),
        .ack      (wr_ack),
        .gnt      (wr_gnt),
        .last     (wr_last),
        .bus_addr (wr_bus_addr)
    );

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int NM = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NM-1:0] rd_req,
    input logic [NM-1:0] rd_lock,
    input logic          rd_ack,
    input logic [NM-1:0] rd_gnt,
    input logic          rd_last,
    input logic [NM-1:0] wr_req,
    input logic [NM-1:0] wr_lock,
    input logic          wr_ack,
    input logic [NM-1:0] wr_gnt,
    input logic          wr_last
);

    a_r1_rd_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_gnt));
    a_r1_wr_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_gnt));

    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (rd_gnt == '0 && wr_gnt == '0));

    a_r3_rd_new_owner_requested: assert property (@(posedge clk) disable iff (rst)
        (rd_gnt != '0 && rd_gnt != $past(rd_gnt)) |-> (($past(rd_req) & rd_gnt) != '0));
    a_r3_wr_new_owner_requested: assert property (@(posedge clk) disable iff (rst)
        (wr_gnt != '0 && wr_gnt != $past(wr_gnt)) |-> (($past(wr_req) & wr_gnt) != '0));

    a_r6_rd_hold_until_final: assert property (@(posedge clk) disable iff (rst)
        (rd_gnt != '0 && !(rd_ack && rd_last)) |=> (rd_gnt == $past(rd_gnt)));
    a_r6_wr_hold_until_final: assert property (@(posedge clk) disable iff (rst)
        (wr_gnt != '0 && !(wr_ack && wr_last)) |=> (wr_gnt == $past(wr_gnt)));

    a_r6_rd_last_needs_owner: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (rd_gnt != '0));
    a_r6_wr_last_needs_owner: assert property (@(posedge clk) disable iff (rst)
        wr_last |-> (wr_gnt != '0));

    a_r9_rd_lock_keeps: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && rd_last && ((rd_gnt & rd_lock) != '0))
        |=> (rd_gnt == '0 || rd_gnt == $past(rd_gnt)));
    a_r9_wr_lock_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && wr_last && ((wr_gnt & wr_lock) != '0))
        |=> (wr_gnt == '0 || wr_gnt == $past(wr_gnt)));

endmodule

bind bus_arbiter bus_arbiter_chk #(.NM(NM)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .rd_lock (rd_lock),
    .rd_ack  (rd_ack),
    .rd_gnt  (rd_gnt),
    .rd_last (rd_last),
    .wr_req  (wr_req),
    .wr_lock (wr_lock),
    .wr_ack  (wr_ack),
    .wr_gnt  (wr_gnt),
    .wr_last (wr_last)
);

// File: tb/tb_bus_arbiter.sv
module tb_bus_arbiter;

    localparam int NM = 4;
    localparam int PW = 2;
    localparam int LW = 4;
    localparam int AW = 32;
    localparam int IW = 2;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  cfg_we;
    logic [IW-1:0]         cfg_idx;
    logic [PW-1:0]         cfg_prio;
    logic [NM-1:0]         rd_req, rd_lock, rd_burst, rd_gnt;
    logic [NM-1:0][LW-1:0] rd_len;
    logic [NM-1:0][AW-1:0] rd_addr;
    logic                  rd_ack, rd_last;
    logic [AW-1:0]         rd_bus_addr;
    logic [NM-1:0]         wr_req, wr_lock, wr_burst, wr_gnt;
    logic [NM-1:0][LW-1:0] wr_len;
    logic [NM-1:0][AW-1:0] wr_addr;
    logic                  wr_ack, wr_last;
    logic [AW-1:0]         wr_bus_addr;

    int total = 0;
    int bad   = 0;
    int pv [NM];
    int last_g;

    bus_arbiter #(.NM(NM), .PW(PW), .LW(LW), .AW(AW)) dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio),
        .rd_req(rd_req), .rd_lock(rd_lock), .rd_burst(rd_burst), .rd_len(rd_len),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_gnt(rd_gnt), .rd_last(rd_last),
        .rd_bus_addr(rd_bus_addr),
        .wr_req(wr_req), .wr_lock(wr_lock), .wr_burst(wr_burst), .wr_len(wr_len),
        .wr_addr(wr_addr), .wr_ack(wr_ack), .wr_gnt(wr_gnt), .wr_last(wr_last),
        .wr_bus_addr(wr_bus_addr)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, tag, act, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_we = 1'b0; cfg_idx = '0; cfg_prio = '0;
        rd_req = '0; rd_lock = '0; rd_burst = '0; rd_ack = 1'b0;
        wr_req = '0; wr_lock = '0; wr_burst = '0; wr_ack = 1'b0;
        for (int i = 0; i < NM; i++) begin
            rd_len[i]  = LW'(1);
            wr_len[i]  = LW'(1);
            rd_addr[i] = 32'h1000_0000 + 32'(i) * 32'h10;
            wr_addr[i] = 32'h2000_0000 + 32'(i) * 32'h10;
            pv[i] = 0;
        end
        tick();
        tick();
        rst = 1'b0;
        last_g = NM - 1;
    endtask

    task automatic set_prio(input int idx, input int val);
        cfg_we   = 1'b1;
        cfg_idx  = IW'(idx);
        cfg_prio = PW'(val);
        tick();
        cfg_we   = 1'b0;
        pv[idx]  = val;
    endtask

    function automatic int exp_win(input int mask, input int lastg);
        int best = -1;
        for (int k = 1; k <= NM; k++) begin
            int i = (lastg + k) % NM;
            if (mask[i] && (best < 0 || pv[i] > pv[best])) best = i;
        end
        return best;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R2: state after reset
        chk_eq("R2 rd_gnt", 32'(rd_gnt), 0);
        chk_eq("R2 wr_gnt", 32'(wr_gnt), 0);
        chk_eq("R2 rd_last", 32'(rd_last), 0);
        chk_eq("R2 rd_bus_addr", rd_bus_addr, 0);
        chk_eq("R2 wr_bus_addr", wr_bus_addr, 0);

        // R5 / R8: equal priorities, all request, back-to-back rotation from master 0
        rd_req = 4'b1111;
        tick();
        chk_eq("R5 first after reset", 32'(rd_gnt), 32'h1);
        rd_ack = 1'b1;
        for (int s = 1; s < 6; s++) begin
            tick();
            chk_eq("R8 rotate no gap", 32'(rd_gnt), 32'(1) << (s % NM));
        end
        rd_req = '0;
        tick();
        chk_eq("R8 idle when none", 32'(rd_gnt), 0);
        rd_ack = 1'b0;

        // R4 / R5 / R12 / R11: sweep all priority sets and request masks on both channels
        do_reset();
        for (int pc = 0; pc < 256; pc++) begin
            for (int i = 0; i < NM; i++) set_prio(i, (pc >> (2 * i)) & 3);
            for (int m = 1; m < 16; m++) begin
                int w;
                rd_req = NM'(m);
                wr_req = NM'(m);
                tick();
                w = exp_win(m, last_g);
                last_g = w;
                chk_eq("R4 rd winner", 32'(rd_gnt), 32'(1) << w);
                chk_eq("R5 wr winner", 32'(wr_gnt), 32'(1) << w);
                chk_eq("R12 rd addr", rd_bus_addr, 32'h1000_0000 + 32'(w) * 32'h10);
                chk_eq("R6 len1 last", 32'(rd_last), 1);
                rd_req = '0; wr_req = '0; rd_ack = 1'b1; wr_ack = 1'b1;
                tick();
                chk_eq("R8 rd release", 32'(rd_gnt), 0);
                chk_eq("R12 idle addr", wr_bus_addr, 0);
                rd_ack = 1'b0; wr_ack = 1'b0;
            end
        end

        // R6: fixed burst of 3, idle ack ignored
        do_reset();
        rd_ack = 1'b1;
        tick();
        chk_eq("R6 idle ack ignored", 32'(rd_gnt), 0);
        rd_ack = 1'b0;
        rd_req[1] = 1'b1; rd_len[1] = LW'(3);
        tick();
        chk_eq("R6 grant m1", 32'(rd_gnt), 32'h2);
        chk_eq("R6 beat1 not last", 32'(rd_last), 0);
        rd_req = '0;
        tick();
        chk_eq("R6 unacked beat held", 32'(rd_gnt), 32'h2);
        rd_ack = 1'b1;
        tick();
        chk_eq("R6 beat2 not last", 32'(rd_last), 0);
        tick();
        chk_eq("R6 beat3 last", 32'(rd_last), 1);
        chk_eq("R6 still owner", 32'(rd_gnt), 32'h2);
        tick();
        chk_eq("R6 released", 32'(rd_gnt), 0);
        rd_ack = 1'b0;

        // R7: variable burst on write channel
        do_reset();
        wr_req[2] = 1'b1; wr_len[2] = '0; wr_burst[2] = 1'b1;
        tick();
        chk_eq("R7 grant m2", 32'(wr_gnt), 32'h4);
        chk_eq("R7 not last", 32'(wr_last), 0);
        wr_req = '0; wr_ack = 1'b1;
        tick();
        tick();
        chk_eq("R7 continues", 32'(wr_gnt), 32'h4);
        wr_burst[2] = 1'b0;
        #1;
        chk_eq("R7 last follows burst", 32'(wr_last), 1);
        tick();
        chk_eq("R7 ended", 32'(wr_gnt), 0);
        wr_ack = 1'b0;

        // R8 / R4: overlapped handover from high-priority m0 to m2
        do_reset();
        set_prio(0, 2);
        set_prio(2, 1);
        rd_req = 4'b0101; rd_len[0] = LW'(2);
        tick();
        chk_eq("R4 high prio wins", 32'(rd_gnt), 32'h1);
        rd_req[0] = 1'b0; rd_ack = 1'b1;
        tick();
        chk_eq("R8 final beat owner", 32'(rd_gnt), 32'h1);
        tick();
        chk_eq("R8 handover no gap", 32'(rd_gnt), 32'h4);
        rd_req = '0;
        tick();
        chk_eq("R8 none left", 32'(rd_gnt), 0);
        rd_ack = 1'b0;

        // R9: lock holds the channel
        do_reset();
        rd_req[1] = 1'b1; rd_lock[1] = 1'b1;
        tick();
        chk_eq("R9 locked grant", 32'(rd_gnt), 32'h2);
        rd_req[1] = 1'b0; rd_req[2] = 1'b1; rd_ack = 1'b1;
        tick();
        rd_ack = 1'b0;
        chk_eq("R9 others blocked", 32'(rd_gnt), 0);
        for (int c = 0; c < 3; c++) begin
            tick();
            chk_eq("R9 still blocked", 32'(rd_gnt), 0);
        end
        rd_req[1] = 1'b1;
        tick();
        chk_eq("R9 holder regrant", 32'(rd_gnt), 32'h2);
        rd_req[1] = 1'b0; rd_lock[1] = 1'b0; rd_ack = 1'b1;
        tick();
        chk_eq("R9 release to m2", 32'(rd_gnt), 32'h4);
        rd_req = '0;
        tick();
        rd_ack = 1'b0;

        // R10: priority write during a burst
        do_reset();
        rd_req[0] = 1'b1; rd_len[0] = LW'(4);
        tick();
        chk_eq("R10 grant m0", 32'(rd_gnt), 32'h1);
        rd_req = 4'b1100; rd_ack = 1'b1;
        cfg_we = 1'b1; cfg_idx = 2'd3; cfg_prio = 2'd3;
        tick();
        cfg_we = 1'b0;
        chk_eq("R10 owner kept", 32'(rd_gnt), 32'h1);
        tick();
        tick();
        chk_eq("R10 owner to end", 32'(rd_gnt), 32'h1);
        chk_eq("R10 final beat", 32'(rd_last), 1);
        tick();
        chk_eq("R10 new prio used", 32'(rd_gnt), 32'h8);
        rd_req = '0;
        tick();
        rd_ack = 1'b0;

        // R11 / R12: concurrent independent owners
        do_reset();
        rd_req[0] = 1'b1; rd_len[0] = LW'(2);
        wr_req[1] = 1'b1;
        tick();
        chk_eq("R11 rd owner", 32'(rd_gnt), 32'h1);
        chk_eq("R11 wr owner", 32'(wr_gnt), 32'h2);
        chk_eq("R12 rd addr m0", rd_bus_addr, 32'h1000_0000);
        chk_eq("R12 wr addr m1", wr_bus_addr, 32'h2000_0010);
        wr_req = '0; rd_req = '0; wr_ack = 1'b1;
        tick();
        wr_ack = 1'b0;
        chk_eq("R11 wr done", 32'(wr_gnt), 0);
        chk_eq("R11 rd unaffected", 32'(rd_gnt), 32'h1);
        rd_ack = 1'b1;
        tick();
        tick();
        chk_eq("R11 rd done", 32'(rd_gnt), 0);
        rd_ack = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule